// File: doc/BRIEF.md
# Wait-State Memory Read Sequencer

This block is the bus-master side of a memory read. A start request opens a three-phase cycle (T1, T2, T3). From T1 through T3 it holds the address steady and drives two active-low strobes to the target: a chip enable and an output enable. T2 repeats as a wait state until the target signals readiness on an active-low acknowledge input. That input is registered before the sequencer acts on it. In the clock after T3 the sequencer releases both strobes. In that same clock it presents the word captured from the read data bus, along with a one-clock done pulse.

A parameter sets a floor on the number of T2 clocks. With it, a target that is known to be slow can be served even if its acknowledge is tied active. A start request that arrives while a cycle is open is dropped. A synchronous reset aborts any cycle and returns the block to idle.

Top module: `rdseq_wait`

## Requirements
- R1: While reset is high and in the clock after it, `ce_n` and `oe_n` are 1, `done` is 0 and `data_out` is 0.
- R2: A start seen at a clock edge while idle makes `ce_n` and `oe_n` go to 0 in the next clock, with `addr_out` equal to the `addr_in` value sampled at that edge.
- R3: `ack_n` is active low and passes through one register. Let D be the number of clock edges after the start edge at which `ack_n` is sampled high before it stays low. The strobes then stay low for 3 + max(D, MIN_WAIT) clocks.
- R4: T2 lasts at least MIN_WAIT + 1 clocks even when `ack_n` is held low throughout, so every cycle keeps the strobes low for at least MIN_WAIT + 3 clocks.
- R5: `data_out` takes the value of `rd_data` at the last clock edge on which the strobes are low, which is the edge that ends T3.
- R6: `done` is high for exactly one clock, in the first clock with `ce_n` back at 1 after a completed cycle. `data_out` holds its value until the next completion.
- R7: A start asserted while a cycle is in progress does not change `addr_out` and does not open a second cycle.
- R8: Reset asserted in the middle of a cycle returns the strobes to 1 in the next clock with no `done` pulse.
- R9: `addr_out` is stable on every clock of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a read cycle |
| addr_in | input | AW | Address to read |
| ack_n | input | 1 | Target ready, active low |
| rd_data | input | DW | Data bus from the target |
| addr_out | output | AW | Address driven to the target |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| data_out | output | DW | Captured read word |
| done | output | 1 | One-clock completion pulse |

## Verification
Two copies of the sequencer run side by side on the same stimulus, one built with MIN_WAIT = 0 and one with MIN_WAIT = 3. The first copy exposes acknowledge-driven stretching from zero waits upward. In the second, acknowledge delays shorter than the floor are masked and longer ones dominate, so both sides of the max(D, MIN_WAIT) rule are reached in the same run. The data bus changes on every clock, which separates capture at the end of T3 from capture one clock early or late.

// File: rtl/rdseq_wait.sv
module rdseq_wait #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int MIN_WAIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic          ack_n,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr_out,
  output logic          ce_n,
  output logic          oe_n,
  output logic [DW-1:0] data_out,
  output logic          done
);
  localparam int WCW = $clog2(MIN_WAIT + 2);

  typedef enum logic [1:0] {S_IDLE, S_T1, S_T2, S_T3} st_t;

  st_t            st;
  logic           ack_q;
  logic [WCW-1:0] wcnt;

  wire floor_met = (wcnt >= WCW'(MIN_WAIT));
  wire go_t3     = ack_q && floor_met;

  assign ce_n = (st == S_IDLE);
  assign oe_n = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ack_q    <= 1'b0;
      wcnt     <= '0;
      addr_out <= '0;
      data_out <= '0;
      done     <= 1'b0;
    end else begin
      ack_q <= ~ack_n;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_out <= addr_in;
          st       <= S_T1;
        end
        S_T1: begin
          wcnt <= '0;
          st   <= S_T2;
        end
        S_T2: begin
          if (go_t3) st <= S_T3;
          else if (!floor_met) wcnt <= wcnt + WCW'(1);
        end
        S_T3: begin
          data_out <= rd_data;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdseq_wait_chk.sv
module rdseq_wait_chk #(
  parameter int AW       = 16,
  parameter int MIN_WAIT = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          done,
  input logic [AW-1:0] addr_out
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)        low_cnt <= '0;
    else if (!ce_n) low_cnt <= low_cnt + 16'd1;
    else            low_cnt <= '0;
  end

  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (ce_n && oe_n && !$past(ce_n))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(ce_n)) |-> done); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !$past(ce_n)) |-> $stable(addr_out)); // R9
  AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(ce_n)) |-> (low_cnt >= 16'(MIN_WAIT + 3))); // R4
endmodule

bind rdseq_wait rdseq_wait_chk #(.AW(AW), .MIN_WAIT(MIN_WAIT)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .done(done), .addr_out(addr_out)
);

// File: tb/tb_rdseq_wait.sv
`timescale 1ns/1ps
module tb_rdseq_wait;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int MW1 = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic ack_n = 1'b1;
  logic [DW-1:0] rd_data = '0;

  logic [AW-1:0] a0, a1;
  logic ce0, ce1, oe0, oe1, d0, d1;
  logic [DW-1:0] q0, q1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rdseq_wait #(.AW(AW), .DW(DW), .MIN_WAIT(0)) dut (
    .clk(clk), .rst(rst), .start(start), .addr_in(addr_in), .ack_n(ack_n),
    .rd_data(rd_data), .addr_out(a0), .ce_n(ce0), .oe_n(oe0),
    .data_out(q0), .done(d0));

  rdseq_wait #(.AW(AW), .DW(DW), .MIN_WAIT(MW1)) dut_w (
    .clk(clk), .rst(rst), .start(start), .addr_in(addr_in), .ack_n(ack_n),
    .rd_data(rd_data), .addr_out(a1), .ce_n(ce1), .oe_n(oe1),
    .data_out(q1), .done(d1));

  function automatic int exp_len(int d, int mw);
    return 3 + ((d > mw) ? d : mw);
  endfunction

  function automatic logic [DW-1:0] bus_word(logic [AW-1:0] a, int i);
    return DW'(a) ^ DW'(i * 32'h3b1 + 32'h55);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic see(int k, int i, int L, logic [AW-1:0] a);
    logic ce, oe, dn;
    logic [AW-1:0] ad;
    logic [DW-1:0] q;
    bit low;
    ce = k ? ce1 : ce0; oe = k ? oe1 : oe0; dn = k ? d1 : d0;
    ad = k ? a1 : a0;   q  = k ? q1 : q0;
    low = (i < L);
    chk(ce == !low, "R3 ce_n length", 32'(ce), 32'(!low));
    chk(oe == !low, "R2 oe_n", 32'(oe), 32'(!low));
    if (low) chk(ad == a, "R9 addr_out", 32'(ad), 32'(a));
    chk(dn == (i == L), "R6 done", 32'(dn), 32'(i == L));
    if (i == L) chk(q == bus_word(a, L - 1), "R5 data_out", 32'(q), 32'(bus_word(a, L - 1)));
  endtask

  task automatic run(logic [AW-1:0] a, int d, bit ign);
    int l0, l1, lm;
    l0 = exp_len(d, 0);
    l1 = exp_len(d, MW1);
    lm = (l0 > l1) ? l0 : l1;
    @(negedge clk);
    start = 1'b1; addr_in = a; ack_n = 1'b1;
    for (int i = 0; i <= lm + 1; i++) begin
      @(posedge clk);
      @(negedge clk);
      start   = ign && (i == 1);
      addr_in = start ? ~a : a;
      ack_n   = (i < d);
      rd_data = bus_word(a, i);
      see(0, i, l0, a);
      see(1, i, l1, a);
    end
    start = 1'b0;
    ack_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(ce0 && oe0 && ce1 && oe1, "R1 strobes in reset", 32'({ce0, oe0, ce1, oe1}), 32'hf);
    chk(!d0 && !d1, "R1 done in reset", 32'({d0, d1}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(q0 == 0 && q1 == 0, "R1 data_out after reset", 32'(q0 | q1), 0);
    chk(ce0 && ce1, "R1 idle after reset", 32'({ce0, ce1}), 32'h3);

    // Directed corners: immediate ack (R2, R4), ack beyond floor (R3), ignored start (R7)
    run(16'h1234, 0, 1'b0);
    run(16'hbeef, 5, 1'b0);
    run(16'h0f0f, 2, 1'b0);
    run(16'ha5a5, 0, 1'b1);
    run(16'h7001, 4, 1'b1);

    // R8 reset in mid-cycle
    @(negedge clk);
    start = 1'b1; addr_in = 16'h4444; ack_n = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(!ce0 && !ce1, "R8 cycle open before reset", 32'({ce0, ce1}), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(ce0 && oe0 && ce1 && oe1, "R8 strobes released", 32'({ce0, oe0, ce1, oe1}), 32'hf);
    chk(!d0 && !d1, "R8 no done", 32'({d0, d1}), 0);
    ack_n = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(ce0 && ce1 && !d0 && !d1, "R8 stays idle", 32'({ce0, ce1, d0, d1}), 32'hc);
    end
    ack_n = 1'b1;

    // Random runs
    for (int n = 0; n < 40; n++) begin
      run(AW'($urandom), int'($urandom % 8), bit'($urandom % 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule